// File: doc/BRIEF.md
# Pre-Bias Aware Buck Start/Stop Sequencer

This block controls when a digitally regulated buck stage starts and stops switching and where its voltage reference sits. When the enable input rises, the block waits a programmed turn-on delay. It then looks once at the sampled output voltage code. An output that is still near zero gets a stepped soft-start ramp of the reference. An output that is already charged starts at the setpoint directly, with no ramp. An output above a hard ceiling is never switched. When enable falls, a turn-off delay runs, and then the reference ramps back down to zero.

A start into an existing output voltage temporarily masks one protection. If the output is above the setpoint, the overvoltage mask is set. If it is at or below the setpoint, the undervoltage mask is set. The mask is released once the output crosses back inside the matching limit. Every start into pre-bias also hands the downstream loop a one-cycle load strobe with an externally computed initial duty code. Two timers watch the rise and the fall and raise sticky timeout flags. The ADC, the compensator and the duty computation are outside this block.

Top module: `pbs_start_seq`

## Requirements
- R1: While rst_ni is low and after release, sw_en_o, ref_o, both masks, duty_load_o and both fault flags are 0.
- R2: sw_en_o rises on the clock edge that comes ton_dly_i+2 edges after the edge that first samples en_i high in the off state.
- R3: If vout_i < pb_lo_i at the check, the reference starts at 0 and rises in 16 steps, one step every max(rise_tick_i,1) cycles. Each of the first 15 steps adds sp/16 (integer division), and the 16th step lands exactly on the setpoint sp. After that the reference follows the setpoint.
- R4: If vout_i > pb_hi_i at the check, switching never starts, no fault flag is set, and the block waits for en_i to fall.
- R5: If pb_lo_i <= vout_i <= pb_hi_i and vout_i > setpoint at the check, the block starts switching at once with ref_o equal to the setpoint and sets ovp_mask_o. The mask clears on the first edge that samples vout_i < ov_lim_i.
- R6: If pb_lo_i <= vout_i <= setpoint at the check, the start is immediate as in R5, but uvp_mask_o is set instead. It clears on the first edge that samples vout_i > uv_lim_i. Only one mask is ever set at a time.
- R7: Each pre-bias start pulses duty_load_o for exactly one cycle, in the cycle switching starts, with duty_o holding duty_init_i.
- R8: A setpoint write (sp_we_i) takes effect only when sp_i <= sp_max_i; otherwise the old setpoint is kept. In regulation, ref_o shows the new setpoint one cycle after the write edge.
- R9: If the output stays outside [uv_lim_i, ov_lim_i] after switching starts, ton_fault_o is set on the edge ton_max_i+1 edges after switching started. On that same edge switching stops and ref_o returns to 0.
- R10: When en_i falls during soft start or regulation, the block keeps switching for toff_dly_i+1 edges. It then ramps the reference down in 16 steps, one every max(fall_tick_i,1) cycles, and clears sw_en_o one edge after the ramp ends, with ref_o at 0.
- R11: toff_fault_o is set if vout_i has not been sampled below pb_lo_i within toff_max_i+1 edges of the start of the fall. Both fault flags clear when a new start begins.
- R12: If en_i falls on the same edge that the turn-on timeout expires, ton_fault_o is still set, but the block takes the turn-off path and keeps switching through the turn-off delay.
- R13: If en_i falls during the turn-on delay or the check, the block returns to off without switching. The next start then shows the full R2 delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Output enable request |
| vout_i | input | CW | Sampled output voltage code |
| sp_we_i | input | 1 | Setpoint write strobe |
| sp_i | input | CW | New setpoint code |
| sp_max_i | input | CW | Largest setpoint that is accepted |
| pb_lo_i | input | CW | Threshold for the no-bias start and for the zero check on stop |
| pb_hi_i | input | CW | Start-refusal ceiling |
| ov_lim_i | input | CW | High output limit |
| uv_lim_i | input | CW | Low output limit |
| ton_dly_i | input | TW | Turn-on delay in cycles |
| toff_dly_i | input | TW | Turn-off delay in cycles |
| rise_tick_i | input | TW | Cycles per soft-start step |
| fall_tick_i | input | TW | Cycles per soft-stop step |
| ton_max_i | input | TW | Turn-on timeout limit |
| toff_max_i | input | TW | Turn-off timeout limit |
| duty_init_i | input | DW | Initial duty code for a pre-bias start |
| ref_o | output | CW | Reference to the regulation loop |
| sw_en_o | output | 1 | Switching enable |
| ovp_mask_o | output | 1 | Overvoltage protection masked |
| uvp_mask_o | output | 1 | Undervoltage protection masked |
| duty_load_o | output | 1 | Load strobe for duty_o |
| duty_o | output | DW | Captured initial duty code |
| ton_fault_o | output | 1 | Turn-on timeout flag |
| toff_fault_o | output | 1 | Turn-off timeout flag |

## Verification
Two events can land on the same edge: the expiry of the turn-on timer and the sampling of enable low. The bench starts from an output held at zero with a short timeout and a slow ramp. It counts edges from the start of switching and drops enable exactly one cycle before the computed expiry edge. After that edge it expects the timeout flag set and switching still on, which shows the turn-off path won over the fault stop. A one-cycle early or late drop gives a different combination, so the exact edge count is what the check rests on.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_TON_DLY, ST_CHECK, ST_SSTART,
    ST_REG, ST_TOFF_DLY, ST_SSTOP, ST_FAULT
  } seq_st_e;
endpackage

// File: rtl/pbs_ramp.sv
module pbs_ramp #(
  parameter int CW      = 12,
  parameter int TW      = 16,
  parameter int STEP_LG = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          up_i,
  input  logic          down_i,
  input  logic          jump_i,
  input  logic          clr_i,
  input  logic [CW-1:0] target_i,
  input  logic [TW-1:0] rise_len_i,
  input  logic [TW-1:0] fall_len_i,
  output logic [CW-1:0] ref_o,
  output logic          busy_o
);
  localparam int NSTEP = 1 << STEP_LG;
  localparam logic [STEP_LG-1:0] LAST = STEP_LG'(NSTEP - 1);

  logic [CW-1:0]      ref_q, inc;
  logic               busy_q, up_q;
  logic [STEP_LG-1:0] stp_q;
  logic [TW-1:0]      tcnt_q, len, len_eff;

  assign inc     = target_i >> STEP_LG;
  assign len     = up_q ? rise_len_i : fall_len_i;
  assign len_eff = (len == '0) ? TW'(1) : len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      busy_q <= 1'b0;
      up_q   <= 1'b1;
      stp_q  <= '0;
      tcnt_q <= '0;
    end else if (clr_i) begin
      ref_q  <= '0;
      busy_q <= 1'b0;
    end else if (up_i) begin
      ref_q  <= '0;
      busy_q <= 1'b1;
      up_q   <= 1'b1;
      stp_q  <= '0;
      tcnt_q <= '0;
    end else if (down_i) begin
      busy_q <= 1'b1;
      up_q   <= 1'b0;
      stp_q  <= '0;
      tcnt_q <= '0;
    end else if (jump_i) begin
      ref_q  <= target_i;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (tcnt_q == len_eff - TW'(1)) begin
        tcnt_q <= '0;
        stp_q  <= stp_q + STEP_LG'(1);
        if (up_q) begin
          if (stp_q == LAST) begin
            ref_q  <= target_i;
            busy_q <= 1'b0;
          end else begin
            ref_q <= ref_q + inc;
          end
        end else if (stp_q == LAST || ref_q <= inc) begin
          ref_q  <= '0;
          busy_q <= 1'b0;
        end else begin
          ref_q <= ref_q - inc;
        end
      end else begin
        tcnt_q <= tcnt_q + TW'(1);
      end
    end
  end

  assign ref_o  = ref_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/pbs_tmo.sv
module pbs_tmo #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          clr_i,
  input  logic          stop_i,
  input  logic [TW-1:0] lim_i,
  output logic          exp_o,
  output logic          flag_o
);
  logic          arm_q, flag_q;
  logic [TW-1:0] cnt_q;

  assign exp_o = arm_q && !stop_i && !start_i && !clr_i && (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b0;
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      arm_q  <= 1'b1;
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      arm_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (arm_q) begin
      if (stop_i) begin
        arm_q <= 1'b0;
      end else if (cnt_q == lim_i) begin
        arm_q  <= 1'b0;
        flag_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + TW'(1);
      end
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pbs_start_seq.sv
module pbs_start_seq
  import pbs_pkg::*;
#(
  parameter int CW      = 12,
  parameter int TW      = 16,
  parameter int DW      = 10,
  parameter int STEP_LG = 4,
  parameter int SP_RST  = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [CW-1:0] vout_i,
  input  logic          sp_we_i,
  input  logic [CW-1:0] sp_i,
  input  logic [CW-1:0] sp_max_i,
  input  logic [CW-1:0] pb_lo_i,
  input  logic [CW-1:0] pb_hi_i,
  input  logic [CW-1:0] ov_lim_i,
  input  logic [CW-1:0] uv_lim_i,
  input  logic [TW-1:0] ton_dly_i,
  input  logic [TW-1:0] toff_dly_i,
  input  logic [TW-1:0] rise_tick_i,
  input  logic [TW-1:0] fall_tick_i,
  input  logic [TW-1:0] ton_max_i,
  input  logic [TW-1:0] toff_max_i,
  input  logic [DW-1:0] duty_init_i,
  output logic [CW-1:0] ref_o,
  output logic          sw_en_o,
  output logic          ovp_mask_o,
  output logic          uvp_mask_o,
  output logic          duty_load_o,
  output logic [DW-1:0] duty_o,
  output logic          ton_fault_o,
  output logic          toff_fault_o
);
  seq_st_e       st_q, st_d;
  logic [TW-1:0] dcnt_q, dcnt_d;
  logic [CW-1:0] sp_q;
  logic          ovp_q, uvp_q, dl_q;
  logic [DW-1:0] duty_q;

  logic below_lo, above_hi, above_sp, in_band;
  logic rmp_up, rmp_dn, rmp_jump, rmp_clr, rmp_busy;
  logic ton_go, toff_go, tmo_clr, ton_exp, ton_stop, toff_exp;
  logic ovp_set, uvp_set, mask_drop;

  assign below_lo = vout_i < pb_lo_i;
  assign above_hi = vout_i > pb_hi_i;
  assign above_sp = vout_i > sp_q;
  assign in_band  = (vout_i >= uv_lim_i) && (vout_i <= ov_lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           sp_q <= CW'(SP_RST);
    else if (sp_we_i && sp_i <= sp_max_i)  sp_q <= sp_i;
  end

  always_comb begin
    st_d     = st_q;
    dcnt_d   = '0;
    rmp_up   = 1'b0;
    rmp_dn   = 1'b0;
    rmp_jump = 1'b0;
    rmp_clr  = 1'b0;
    ton_go   = 1'b0;
    toff_go  = 1'b0;
    tmo_clr  = 1'b0;
    ovp_set  = 1'b0;
    uvp_set  = 1'b0;
    unique case (st_q)
      ST_OFF: if (en_i) begin
        st_d    = ST_TON_DLY;
        tmo_clr = 1'b1;
      end
      ST_TON_DLY: begin
        dcnt_d = dcnt_q + TW'(1);
        if (!en_i)                   st_d = ST_OFF;
        else if (dcnt_q >= ton_dly_i) st_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (!en_i)         st_d = ST_OFF;
        else if (above_hi) st_d = ST_FAULT;
        else if (below_lo) begin
          st_d   = ST_SSTART;
          rmp_up = 1'b1;
          ton_go = 1'b1;
        end else begin
          st_d     = ST_REG;
          rmp_jump = 1'b1;
          ton_go   = 1'b1;
          ovp_set  = above_sp;
          uvp_set  = !above_sp;
        end
      end
      ST_SSTART: begin
        if (!en_i) st_d = ST_TOFF_DLY;
        else if (ton_exp) begin
          st_d    = ST_FAULT;
          rmp_clr = 1'b1;
        end else if (!rmp_busy) st_d = ST_REG;
      end
      ST_REG: begin
        if (!en_i) st_d = ST_TOFF_DLY;
        else if (ton_exp) begin
          st_d    = ST_FAULT;
          rmp_clr = 1'b1;
        end else rmp_jump = 1'b1;
      end
      ST_TOFF_DLY: begin
        dcnt_d = dcnt_q + TW'(1);
        if (dcnt_q >= toff_dly_i) begin
          st_d    = ST_SSTOP;
          rmp_dn  = 1'b1;
          toff_go = 1'b1;
        end
      end
      ST_SSTOP: if (!rmp_busy) st_d = ST_OFF;
      ST_FAULT: if (!en_i) st_d = ST_OFF;
      default:  st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OFF;
      dcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      dcnt_q <= dcnt_d;
    end
  end

  // masks only live while the output is actively held up
  assign mask_drop = st_d inside {ST_OFF, ST_FAULT, ST_TOFF_DLY};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovp_q  <= 1'b0;
      uvp_q  <= 1'b0;
      dl_q   <= 1'b0;
      duty_q <= '0;
    end else begin
      dl_q <= ovp_set | uvp_set;
      if (ovp_set | uvp_set) duty_q <= duty_init_i;
      if (mask_drop)                      ovp_q <= 1'b0;
      else if (ovp_set)                   ovp_q <= 1'b1;
      else if (ovp_q && vout_i < ov_lim_i) ovp_q <= 1'b0;
      if (mask_drop)                      uvp_q <= 1'b0;
      else if (uvp_set)                   uvp_q <= 1'b1;
      else if (uvp_q && vout_i > uv_lim_i) uvp_q <= 1'b0;
    end
  end

  pbs_ramp #(.CW(CW), .TW(TW), .STEP_LG(STEP_LG)) u_ramp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .up_i       (rmp_up),
    .down_i     (rmp_dn),
    .jump_i     (rmp_jump),
    .clr_i      (rmp_clr),
    .target_i   (sp_q),
    .rise_len_i (rise_tick_i),
    .fall_len_i (fall_tick_i),
    .ref_o      (ref_o),
    .busy_o     (rmp_busy)
  );

  assign ton_stop = in_band || !(st_q inside {ST_SSTART, ST_REG});

  pbs_tmo #(.TW(TW)) u_ton_tmo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ton_go),
    .clr_i   (tmo_clr),
    .stop_i  (ton_stop),
    .lim_i   (ton_max_i),
    .exp_o   (ton_exp),
    .flag_o  (ton_fault_o)
  );

  pbs_tmo #(.TW(TW)) u_toff_tmo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (toff_go),
    .clr_i   (tmo_clr),
    .stop_i  (below_lo),
    .lim_i   (toff_max_i),
    .exp_o   (toff_exp),
    .flag_o  (toff_fault_o)
  );

  logic unused_exp;
  assign unused_exp = toff_exp;

  assign sw_en_o     = st_q inside {ST_SSTART, ST_REG, ST_TOFF_DLY, ST_SSTOP};
  assign ovp_mask_o  = ovp_q;
  assign uvp_mask_o  = uvp_q;
  assign duty_load_o = dl_q;
  assign duty_o      = duty_q;
endmodule

// File: rtl/pbs_chk.sv
module pbs_chk #(
  parameter int CW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          sw_en_o,
  input logic [CW-1:0] ref_o,
  input logic          ovp_mask_o,
  input logic          uvp_mask_o,
  input logic          duty_load_o,
  input logic          ton_fault_o
);
  // R6
  mask_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovp_mask_o && uvp_mask_o));

  // R5
  ovp_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovp_mask_o) |-> $rose(sw_en_o));

  // R7
  load_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_load_o |=> !duty_load_o);

  // R7
  load_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_load_o |-> (sw_en_o && !$past(sw_en_o)));

  // R9
  ton_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ton_fault_o) && $past(en_i)) |-> !sw_en_o);

  // R12
  ton_vs_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ton_fault_o) && !$past(en_i)) |-> sw_en_o);

  // R10
  ref_zero_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_en_o) |-> (ref_o == '0));
endmodule

bind pbs_start_seq pbs_chk #(.CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .sw_en_o     (sw_en_o),
  .ref_o       (ref_o),
  .ovp_mask_o  (ovp_mask_o),
  .uvp_mask_o  (uvp_mask_o),
  .duty_load_o (duty_load_o),
  .ton_fault_o (ton_fault_o)
);

// File: tb/pbs_start_seq_test.sv
module pbs_start_seq_test;
  localparam int CW = 12, TW = 16, DW = 10, N = 16;

  logic clk = 1'b0, rst_ni = 1'b0, en = 1'b0, sp_we = 1'b0;
  logic [CW-1:0] vout = '0, sp = '0, sp_max = 12'd2500, pb_lo = 12'd372, pb_hi = 12'd3000;
  logic [CW-1:0] ov = '0, uv = '0;
  logic [TW-1:0] ton_d = '0, toff_d = '0, rise_t = 16'd1, fall_t = 16'd1;
  logic [TW-1:0] ton_mx = 16'd1000, toff_mx = 16'd1000;
  logic [DW-1:0] duty_in = '0;
  logic [CW-1:0] ref_v;
  logic sw_en, ovp_m, uvp_m, dload, ton_f, toff_f;
  logic [DW-1:0] duty_v;

  int n_chk = 0, n_bad = 0, cur_sp = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pbs_start_seq #(.CW(CW), .TW(TW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .vout_i(vout),
    .sp_we_i(sp_we), .sp_i(sp), .sp_max_i(sp_max), .pb_lo_i(pb_lo), .pb_hi_i(pb_hi),
    .ov_lim_i(ov), .uv_lim_i(uv), .ton_dly_i(ton_d), .toff_dly_i(toff_d),
    .rise_tick_i(rise_t), .fall_tick_i(fall_t), .ton_max_i(ton_mx), .toff_max_i(toff_mx),
    .duty_init_i(duty_in), .ref_o(ref_v), .sw_en_o(sw_en), .ovp_mask_o(ovp_m),
    .uvp_mask_o(uvp_m), .duty_load_o(dload), .duty_o(duty_v),
    .ton_fault_o(ton_f), .toff_fault_o(toff_f)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected setpoint follows the acceptance rule of R8
  task automatic write_sp(int v);
    sp = CW'(v); sp_we = 1'b1;
    tick();
    sp_we = 1'b0;
    if (v <= int'(sp_max)) cur_sp = v;
    ov = CW'(cur_sp + 100);
    uv = CW'(cur_sp - 100);
  endtask

  task automatic go_on(output int k);
    en = 1'b1; k = 0;
    do begin tick(); k++; end while (!sw_en && k < 300);
  endtask

  task automatic go_off(output int k);
    en = 1'b0; k = 0;
    do begin tick(); k++; end while (sw_en && k < 3000);
  endtask

  function automatic int on_edges(int d);
    return d + 3;
  endfunction

  function automatic int off_edges(int d, int t);
    return d + N * ((t == 0) ? 1 : t) + 3;
  endfunction

  initial begin
    int k;
    void'($urandom(32'd4242));
    repeat (3) tick();
    // R1
    chk("R1 sw_en in reset", sw_en, 0);
    chk("R1 ref in reset", ref_v, 0);
    chk("R1 masks in reset", ovp_m | uvp_m, 0);
    chk("R1 faults in reset", ton_f | toff_f | dload, 0);
    rst_ni = 1'b1;
    tick();
    chk("R1 sw_en after reset", sw_en, 0);
    write_sp(1600);

    // R2 R3: normal start, inc = 100
    ton_d = 16'd5; rise_t = 16'd3; vout = '0;
    go_on(k);
    chk("R2 turn-on delay", k, on_edges(5));
    chk("R3 ref at start", ref_v, 0);
    chk("R3 masks off on normal start", ovp_m | uvp_m | dload, 0);
    vout = 12'd1600;
    repeat (2) tick();
    chk("R3 ref before first step", ref_v, 0);
    tick();
    chk("R3 first step", ref_v, 100);
    repeat ((N - 1) * 3 - 1) tick();
    chk("R3 ref before last step", ref_v, 1500);
    tick();
    chk("R3 ref at setpoint", ref_v, 1600);
    repeat (3) tick();

    // R8
    write_sp(2600);
    tick();
    chk("R8 oversize setpoint ignored", ref_v, 1600);
    write_sp(2500);
    tick();
    chk("R8 setpoint at max taken", ref_v, 2500);
    write_sp(1600);
    tick();
    vout = 12'd1600;

    // R10
    toff_d = 16'd4; fall_t = 16'd2; vout = '0;
    go_off(k);
    chk("R10 turn-off sequence length", k, off_edges(4, 2));
    chk("R10 ref zero when off", ref_v, 0);
    chk("R11 no stop timeout", toff_f, 0);
    chk("R9 no start timeout", ton_f, 0);

    // R4
    ton_d = 16'd2; vout = 12'd3500;
    en = 1'b1;
    repeat (20) tick();
    chk("R4 refused start no switching", sw_en, 0);
    chk("R4 refused start no faults", ton_f | toff_f | ovp_m | uvp_m, 0);
    en = 1'b0; repeat (2) tick();

    // R5 R7
    vout = 12'd1900; duty_in = 10'd321;
    go_on(k);
    chk("R5 pre-bias delay", k, on_edges(2));
    chk("R5 ovp mask set", ovp_m, 1);
    chk("R5 uvp mask clear", uvp_m, 0);
    chk("R5 ref jumps to setpoint", ref_v, 1600);
    chk("R7 load strobe", dload, 1);
    chk("R7 duty code", duty_v, 321);
    tick();
    chk("R7 load strobe one cycle", dload, 0);
    chk("R5 ovp mask held above limit", ovp_m, 1);
    vout = 12'd1650;
    tick();
    chk("R5 ovp mask released", ovp_m, 0);
    vout = '0;
    go_off(k);
    chk("R10 off after pre-bias", sw_en, 0);

    // R6
    vout = 12'd1000; duty_in = 10'd77;
    go_on(k);
    chk("R6 uvp mask set", uvp_m, 1);
    chk("R6 ovp mask clear", ovp_m, 0);
    chk("R7 duty code low branch", duty_v, 77);
    tick();
    chk("R6 uvp mask held below limit", uvp_m, 1);
    vout = 12'd1550;
    tick();
    chk("R6 uvp mask released", uvp_m, 0);
    vout = '0;
    go_off(k);

    // R9
    rise_t = 16'd10; ton_mx = 16'd20; vout = '0;
    go_on(k);
    repeat (20) tick();
    chk("R9 no fault before limit", ton_f, 0);
    chk("R9 switching before limit", sw_en, 1);
    tick();
    chk("R9 fault at limit", ton_f, 1);
    chk("R9 switching stopped", sw_en, 0);
    chk("R9 ref cleared", ref_v, 0);
    en = 1'b0; repeat (2) tick();

    // R12: enable drop sampled on the expiry edge
    go_on(k);
    chk("R11 start clears fault", ton_f, 0);
    repeat (20) tick();
    en = 1'b0;
    tick();
    chk("R12 fault still raised", ton_f, 1);
    chk("R12 turn-off path keeps switching", sw_en, 1);
    go_off(k);
    chk("R12 eventually off", sw_en, 0);

    // R11
    rise_t = 16'd1; ton_mx = 16'd1000; vout = '0;
    go_on(k);
    vout = 12'd1600;
    repeat (20) tick();
    toff_mx = 16'd5; fall_t = 16'd3;
    go_off(k);
    chk("R11 stop timeout raised", toff_f, 1);
    vout = '0;
    go_on(k);
    chk("R11 start clears stop fault", toff_f, 0);
    toff_mx = 16'd1000;
    go_off(k);

    // R13
    ton_d = 16'd10; vout = '0;
    en = 1'b1; repeat (3) tick();
    en = 1'b0; repeat (2) tick();
    chk("R13 abort in delay no switching", sw_en, 0);
    ton_d = 16'd3;
    go_on(k);
    chk("R13 full delay after abort", k, on_edges(3));
    repeat (2) tick();
    en = 1'b0;
    tick();
    chk("R13 soft-start abort uses turn-off path", sw_en, 1);
    go_off(k);
    chk("R13 off after aborted ramp", sw_en, 0);

    // random starts: R2 R5 R6 R10
    for (int i = 0; i < 12; i++) begin
      int cls, d, td, s;
      s = 800 + 100 * $urandom_range(0, 16);
      write_sp(s);
      d = $urandom_range(0, 6);
      td = $urandom_range(0, 5);
      ton_d = TW'(d); toff_d = TW'(td); rise_t = 16'd1; fall_t = 16'd1;
      cls = $urandom_range(0, 2);
      if (cls == 0)      vout = CW'($urandom_range(0, 371));
      else if (cls == 1) vout = CW'($urandom_range(cur_sp + 101, 2999));
      else               vout = CW'($urandom_range(372, cur_sp));
      go_on(k);
      chk("R2 random delay", k, on_edges(d));
      chk("R5 random ovp mask", ovp_m, (cls == 1) ? 1 : 0);
      chk("R6 random uvp mask", uvp_m, (cls == 2) ? 1 : 0);
      chk("R3 random start ref", ref_v, (cls == 0) ? 0 : cur_sp);
      vout = CW'(cur_sp);
      repeat (20) tick();
      chk("R3 random settled ref", ref_v, cur_sp);
      vout = '0;
      go_off(k);
      chk("R10 random stop length", k, off_edges(td, 1));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule